// File: doc/BRIEF.md
# Port-Routed Edge Interrupt Controller

This block watches sixteen interrupt lines. Each line can be fed from the pin of the same index on any one of up to sixteen input ports. A small register file controls it. For each line, software picks the source port, enables detection of rising transitions, falling transitions or both, and sets an unmask bit. The selected level passes through a two-flop synchroniser. A transition found against the previous synchronised sample latches a rising or a falling pending flag, and software clears that flag by writing a one to it.

The unmasked pending flags are reduced onto three registered request outputs of unequal size: lines 0 and 1, lines 2 and 3, and lines 4 through 15. A pending flag is latched whether or not its line is unmasked. Changing a line's source port is blanked, so the switch itself never produces an edge. If a new edge and a clear of the same flag arrive in the same cycle, the edge is kept.

Top module: `edge_irq_router`

## Requirements
- R1: Line n (0..15) samples `port_pins[p*16+n]`, where p is the port held in line n's selector. A transition on pin n of any port that is not selected leaves line n's pending flags unchanged.
- R2: The selectors are 4-bit fields, four per word, at register addresses 8 to 11. Line n uses the word at address 8+n/4, bits 4*(n mod 4)+3 down to 4*(n mod 4).
- R3: When bit n of the rising-enable register (address 1) is 1, a synchronised 0-to-1 transition on line n sets bit n of the rising-pending register (address 3). No rising-pending bit becomes set while its enable bit is 0.
- R4: When bit n of the falling-enable register (address 2) is 1, a synchronised 1-to-0 transition sets bit n of the falling-pending register (address 4). Both enables may be set together on one line.
- R5: Writing to address 3 or 4 clears each pending bit whose data bit is 1. Pending bits whose data bit is 0 are unchanged.
- R6: If an enabled edge on a line and a write of 1 to that line's pending bit take effect on the same clock edge, the pending bit stays 1.
- R7: A line requests an interrupt only while it has a rising or falling pending bit and its bit in the unmask register (address 0) is 1. Pending bits are set while the line is masked. Unmasking a line that is already pending raises its request on the clock edge after the unmask write takes effect.
- R8: `irq_grp[0]` is the OR of the requests of lines 0 and 1. `irq_grp[1]` is the OR of lines 2 and 3. `irq_grp[2]` is the OR of lines 4 through 15.
- R9: Writing a new port into a line's selector does not set either pending bit of that line, even when the old and new pins are at different levels. Transitions that occur after the blanking window of four cycles are detected normally.
- R10: All registers reset to 0, and `irq_grp` resets to 0. `bus_rdata` returns the addressed register one clock after the address is presented. Bits 31 to 16 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for `bus_addr` |
| port_pins | input | 256 | Port inputs; port p pin n at bit p*16+n |
| irq_grp | output | 3 | Grouped interrupt requests |

## Verification
The bench times a clear write to land on exactly the clock edge where a new rising edge latches. A design that gives priority to the clear would drop that event, and the bit would read back 0. It moves a line between two ports that sit at opposite levels and then checks both pending flags. A router without blanking would report a false rising or falling edge there. It also checks that an unmask with a stale pending flag raises the correct group one cycle later, and that each line lands in its own group. Swapped group boundaries, or a pending latch that ignored masked lines, would show up on the wrong or a silent output.

// File: rtl/erq_pkg.sv
package erq_pkg;
  localparam int ADDR_UNMASK = 0;
  localparam int ADDR_REN    = 1;
  localparam int ADDR_FEN    = 2;
  localparam int ADDR_RPEND  = 3;
  localparam int ADDR_FPEND  = 4;
  localparam int ADDR_SEL0   = 8;
endpackage

// File: rtl/erq_line.sv
module erq_line #(
  parameter int NUM_PORTS = 16,
  parameter int SEL_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SEL_W-1:0]     sel,
  input  logic [NUM_PORTS-1:0] pins,
  output logic                 rise,
  output logic                 fall
);
  logic             raw;
  logic             sync1, sync2, prev;
  logic [SEL_W-1:0] sel_q;
  logic [1:0]       blank;

  always_comb begin
    raw = 1'b0;
    if (int'(sel) < NUM_PORTS) raw = pins[sel];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      prev  <= 1'b0;
      sel_q <= '0;
      blank <= 2'd0;
    end else begin
      sync1 <= raw;
      sync2 <= sync1;
      prev  <= sync2;
      sel_q <= sel;
      if (sel != sel_q) blank <= 2'd3;
      else if (blank != 2'd0) blank <= blank - 2'd1;
    end
  end

  assign rise = (blank == 2'd0) && sync2 && !prev;
  assign fall = (blank == 2'd0) && !sync2 && prev;

  // R9: a selector change is followed by a quiet cycle
  p_sel_change_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (sel != sel_q) |=> (!rise && !fall));
endmodule

// File: rtl/erq_regs.sv
module erq_regs
  import erq_pkg::*;
#(
  parameter int LINES         = 16,
  parameter int SEL_W         = 4,
  parameter int SELS_PER_WORD = 4,
  parameter int DW            = 32,
  parameter int AW            = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          wdata,
  input  logic [LINES-1:0]       rise_vec,
  input  logic [LINES-1:0]       fall_vec,
  output logic [LINES-1:0]       unmask,
  output logic [LINES-1:0]       rpend,
  output logic [LINES-1:0]       fpend,
  output logic [LINES*SEL_W-1:0] sel_flat,
  output logic [DW-1:0]          rdata
);
  localparam int WB        = SELS_PER_WORD * SEL_W;
  localparam int SEL_WORDS = LINES / SELS_PER_WORD;

  logic [LINES-1:0] ren, fen;
  logic [LINES-1:0] rclr, fclr, rise_hit, fall_hit;
  logic [DW-LINES-1:0] unused_wdata_hi;

  assign unused_wdata_hi = wdata[DW-1:LINES];

  assign rclr     = (we && addr == AW'(ADDR_RPEND)) ? wdata[LINES-1:0] : '0;
  assign fclr     = (we && addr == AW'(ADDR_FPEND)) ? wdata[LINES-1:0] : '0;
  assign rise_hit = rise_vec & ren;
  assign fall_hit = fall_vec & fen;

  always_ff @(posedge clk) begin
    if (rst) begin
      unmask   <= '0;
      ren      <= '0;
      fen      <= '0;
      rpend    <= '0;
      fpend    <= '0;
      sel_flat <= '0;
    end else begin
      if (we && addr == AW'(ADDR_UNMASK)) unmask <= wdata[LINES-1:0];
      if (we && addr == AW'(ADDR_REN))    ren    <= wdata[LINES-1:0];
      if (we && addr == AW'(ADDR_FEN))    fen    <= wdata[LINES-1:0];
      rpend <= (rpend & ~rclr) | rise_hit;
      fpend <= (fpend & ~fclr) | fall_hit;
      for (int k = 0; k < SEL_WORDS; k++) begin
        if (we && addr == AW'(ADDR_SEL0 + k)) sel_flat[k*WB +: WB] <= wdata[WB-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= '0;
      if (addr == AW'(ADDR_UNMASK)) rdata[LINES-1:0] <= unmask;
      if (addr == AW'(ADDR_REN))    rdata[LINES-1:0] <= ren;
      if (addr == AW'(ADDR_FEN))    rdata[LINES-1:0] <= fen;
      if (addr == AW'(ADDR_RPEND))  rdata[LINES-1:0] <= rpend;
      if (addr == AW'(ADDR_FPEND))  rdata[LINES-1:0] <= fpend;
      for (int k = 0; k < SEL_WORDS; k++) begin
        if (addr == AW'(ADDR_SEL0 + k)) rdata[WB-1:0] <= sel_flat[k*WB +: WB];
      end
    end
  end

  // R5: a clear with no competing edge leaves the bit at 0
  p_w1c_r5: assert property (@(posedge clk) disable iff (rst)
    (we && addr == AW'(ADDR_RPEND)) |=> ((rpend & $past(rclr & ~rise_hit)) == '0));
  // R6: an enabled edge always leaves its bit set, even against a clear
  p_edge_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (|rise_hit) |=> ((rpend & $past(rise_hit)) == $past(rise_hit)));
  // R3: no rising-pending bit appears without its enable
  p_rise_needs_en_r3: assert property (@(posedge clk) disable iff (rst)
    ((rpend & ~$past(rpend) & ~$past(ren)) == '0));
  // R4: no falling-pending bit appears without its enable
  p_fall_needs_en_r4: assert property (@(posedge clk) disable iff (rst)
    ((fpend & ~$past(fpend) & ~$past(fen)) == '0));
endmodule

// File: rtl/edge_irq_router.sv
module edge_irq_router #(
  parameter int LINES      = 16,
  parameter int NUM_PORTS  = 16,
  parameter int SEL_W      = 4,
  parameter int DW         = 32,
  parameter int AW         = 4,
  parameter int GRP_A_LAST = 1,
  parameter int GRP_B_LAST = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_we,
  input  logic [AW-1:0]              bus_addr,
  input  logic [DW-1:0]              bus_wdata,
  output logic [DW-1:0]              bus_rdata,
  input  logic [NUM_PORTS*LINES-1:0] port_pins,
  output logic [2:0]                 irq_grp
);
  logic [LINES-1:0]       rise_vec, fall_vec;
  logic [LINES-1:0]       unmask, rpend, fpend, active;
  logic [LINES*SEL_W-1:0] sel_flat;

  for (genvar n = 0; n < LINES; n++) begin : g_line
    logic [NUM_PORTS-1:0] col;
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_col
      assign col[p] = port_pins[p*LINES + n];
    end
    erq_line #(.NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) u_line (
      .clk  (clk),
      .rst  (rst),
      .sel  (sel_flat[n*SEL_W +: SEL_W]),
      .pins (col),
      .rise (rise_vec[n]),
      .fall (fall_vec[n])
    );
  end

  erq_regs #(.LINES(LINES), .SEL_W(SEL_W), .SELS_PER_WORD(4), .DW(DW), .AW(AW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .we       (bus_we),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .rise_vec (rise_vec),
    .fall_vec (fall_vec),
    .unmask   (unmask),
    .rpend    (rpend),
    .fpend    (fpend),
    .sel_flat (sel_flat),
    .rdata    (bus_rdata)
  );

  assign active = (rpend | fpend) & unmask;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_grp <= '0;
    end else begin
      irq_grp[0] <= |active[GRP_A_LAST:0];
      irq_grp[1] <= |active[GRP_B_LAST:GRP_A_LAST+1];
      irq_grp[2] <= |active[LINES-1:GRP_B_LAST+1];
    end
  end

  // R7: with every line masked the request outputs go quiet
  p_masked_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (unmask == '0) |=> (irq_grp == 3'b000));
  // R8: a group request implies some pending line existed
  p_grp_needs_pend_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_grp != 3'b000) |-> ($past(rpend | fpend) != '0));
endmodule

// File: tb/edge_irq_router_bench.sv
module edge_irq_router_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_we = 1'b0;
  logic [3:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [255:0] pins = '0;
  logic [2:0]   irq_grp;

  int nchk = 0;
  int nerr = 0;
  logic [15:0] sel_sh [4];

  always #2.5 clk = ~clk;

  edge_irq_router u_edge_irq_router (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .port_pins (pins),
    .irq_grp   (irq_grp)
  );

  // {line[13:10], port[9:6], ren, fen, init, fin, exp_rise, exp_fall}
  localparam logic [13:0] VEC [8] = '{
    {4'd0,  4'd0,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {4'd1,  4'd3,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    {4'd5,  4'd15, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {4'd7,  4'd9,  1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    {4'd15, 4'd2,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'd10, 4'd6,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'd3,  4'd12, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'd12, 4'd1,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic set_sel(input int line, input int port);
    sel_sh[line/4][4*(line%4) +: 4] = 4'(port);
    wr(4'(8 + line/4), {16'h0, sel_sh[line/4]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int k = 0; k < 4; k++) sel_sh[k] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R10: reset values
    for (int a = 0; a < 12; a++) begin
      if (a < 5 || a > 7) begin
        rd(4'(a), d);
        check($sformatf("R10 reset reg %0d", a), d, 32'h0);
      end
    end
    check("R10 reset irq", {29'h0, irq_grp}, 32'h0);

    // R10 / R2: upper bits read zero, selector field placement
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, d);
    check("R10 unmask width", d, 32'h0000_FFFF);
    wr(4'd0, 32'h0);
    wr(4'd9, 32'hFFFF_A000);
    rd(4'd9, d);
    check("R2 selector word 9 readback", d, 32'h0000_A000);
    wr(4'd9, 32'h0);

    // Table: routing and edge polarity (R1, R2, R3, R4)
    for (int i = 0; i < 8; i++) begin
      int line, port;
      logic ren, fen, ini, fin, er, ef;
      line = int'(VEC[i][13:10]);
      port = int'(VEC[i][9:6]);
      {ren, fen, ini, fin, er, ef} = VEC[i][5:0];
      pins = '0;
      set_sel(line, port);
      wr(4'd1, 32'(ren) << line);
      wr(4'd2, 32'(fen) << line);
      pins[port*16 + line] = ini;
      idle(6);
      wr(4'd3, 32'hFFFF);
      wr(4'd4, 32'hFFFF);
      idle(2);
      pins[port*16 + line] = fin;
      idle(6);
      rd(4'd3, d);
      check($sformatf("R3 R1 vector %0d rising pend", i), d, 32'(er) << line);
      rd(4'd4, d);
      check($sformatf("R4 R2 vector %0d falling pend", i), d, 32'(ef) << line);
    end

    // R1: unselected port pin has no effect (line 12 is on port 1)
    wr(4'd3, 32'hFFFF); wr(4'd4, 32'hFFFF);
    pins[7*16 + 12] = 1'b1;
    idle(6);
    rd(4'd3, d);
    check("R1 unselected port ignored (rising)", d, 32'h0);
    pins[7*16 + 12] = 1'b0;
    idle(6);
    rd(4'd4, d);
    check("R1 unselected port ignored (falling)", d, 32'h0);

    // R6: edge and clear on the same clock edge, line 9 on port 4
    pins = '0;
    set_sel(9, 4);
    wr(4'd1, 32'h0200); wr(4'd2, 32'h0);
    idle(6);
    pins[4*16 + 9] = 1'b1;
    idle(6);
    pins[4*16 + 9] = 1'b0;
    idle(6);
    rd(4'd3, d);
    check("R3 line 9 pending before collision", d, 32'h0200);
    @(negedge clk); pins[4*16 + 9] = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_we = 1'b1; bus_addr = 4'd3; bus_wdata = 32'h0200;
    @(negedge clk); bus_we = 1'b0;
    rd(4'd3, d);
    check("R6 edge beats simultaneous clear", d, 32'h0200);

    // R5: zero write keeps, one write clears
    wr(4'd3, 32'h0);
    rd(4'd3, d);
    check("R5 write of 0 keeps bit", d, 32'h0200);
    wr(4'd3, 32'h0200);
    rd(4'd3, d);
    check("R5 write of 1 clears bit", d, 32'h0);

    // R7 / R8: masking and grouping
    pins = '0;
    set_sel(1, 0); set_sel(2, 0); set_sel(4, 0); set_sel(15, 0);
    wr(4'd1, 32'h8016); wr(4'd2, 32'h0);
    idle(6);
    wr(4'd3, 32'hFFFF); wr(4'd4, 32'hFFFF);
    pins[1] = 1'b1;
    idle(6);
    check("R7 masked line stays quiet", {29'h0, irq_grp}, 32'h0);
    rd(4'd3, d);
    check("R7 pending set while masked", d, 32'h0002);
    wr(4'd0, 32'h0002);
    idle(1);
    check("R7 R8 unmask raises group 0", {29'h0, irq_grp}, 32'h1);
    wr(4'd3, 32'h0002);
    idle(1);
    check("R7 clear drops request", {29'h0, irq_grp}, 32'h0);
    wr(4'd0, 32'h0004);
    pins[2] = 1'b1;
    idle(6);
    check("R8 line 2 on group 1", {29'h0, irq_grp}, 32'h2);
    wr(4'd3, 32'h0004);
    wr(4'd0, 32'h8010);
    pins[4] = 1'b1;
    idle(6);
    check("R8 line 4 on group 2", {29'h0, irq_grp}, 32'h4);
    wr(4'd3, 32'h0010);
    pins[15] = 1'b1;
    idle(6);
    check("R8 line 15 on group 2", {29'h0, irq_grp}, 32'h4);
    wr(4'd3, 32'hFFFF);
    wr(4'd0, 32'h0);

    // R9: selector change between opposite levels, line 8
    pins = '0;
    pins[5*16 + 8] = 1'b1;
    set_sel(8, 0);
    wr(4'd1, 32'h0100); wr(4'd2, 32'h0100);
    idle(6);
    wr(4'd3, 32'hFFFF); wr(4'd4, 32'hFFFF);
    set_sel(8, 5);
    idle(8);
    rd(4'd3, d);
    check("R9 switch to high port: no rising", d & 32'h0100, 32'h0);
    set_sel(8, 0);
    idle(8);
    rd(4'd4, d);
    check("R9 switch to low port: no falling", d & 32'h0100, 32'h0);
    pins[0*16 + 8] = 1'b1;
    idle(6);
    rd(4'd3, d);
    check("R9 real edge after blanking", d & 32'h0100, 32'h0100);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end
endmodule